// File: doc/BRIEF.md
# I2C Register-Addressed Wiper Controller

This block is the serial-bus target that sets the tap of a digitally controlled potentiometer. A bus controller selects it with an identification byte made of a fixed device code, a zero bit, two address bits strapped on input pins and a read/write flag. A register address byte follows. In a write, each later data byte goes to the addressed register. In a read, the controller sends a repeated START and a second identification byte with the read flag set. The block then returns register contents for as long as the controller acknowledges. The register address steps up by one after every data byte in both directions.

The 7-bit wiper register drives the tap code output. Code 7Fh selects the tap nearest the high terminal and 00h selects the tap nearest the low terminal. A shadow register stands in for non-volatile storage. After reset, a recall delay runs, and then the wiper loads from the shadow. Software copies the wiper into the shadow by setting a control bit, and a busy flag stays set for a programmable number of cycles after that. An active-low shutdown input raises a shutdown flag. It leaves the wiper and the bus interface working.

SCL and SDA each pass through a two-flop synchronizer and a stability filter before edges are detected. The block samples SDA when SCL rises. It changes its open-drain pull only after SCL falls, or after START or STOP.

Top module: `i2c_wiper_ctrl`

## Requirements
- R1: An SDA fall while SCL is high (START) begins a new identification byte from any state, including in the middle of a transfer. An SDA rise while SCL is high (STOP) releases SDA and returns the block to idle. In idle, clocked bytes get no acknowledge and change nothing.
- R2: While reset is held, and after it, the SDA pull output is inactive. The tap output reads 00h until the recall completes.
- R3: The identification byte, MSB first, is DEV_CODE[3:0], a 0, A1, A0, then R/W in bit 0. On a match the block pulls SDA low in the ninth clock. On any mismatch it leaves SDA released and ignores the bus until the next START.
- R4: A write is identification (R/W=0), register address, then data bytes, and each byte is acknowledged. Each data byte goes to the current address, and the address then increments by one.
- R5: A read is identification (R/W=0), address, repeated START, then identification (R/W=1). The block then sends the register at the current address, MSB first, and increments the address after each byte. It sends the next byte only after the controller acknowledges. After a NACK it keeps SDA released.
- R6: Register map. 00h is the wiper, in bits 6:0, and bit 7 reads 0. 01h is control: writing bit 0 as 1 requests a store, and a read returns the busy flag in bit 0 and the shutdown flag in bit 1. 02h reads back the shadow value. Every other address reads 00h, and writes to it are acknowledged and discarded.
- R7: The tap output always equals the wiper register. Every written value from 00h to 7Fh appears there unchanged.
- R8: RECALL_CYC cycles after reset is released, the wiper loads the shadow value. The shadow holds NV_INIT after reset.
- R9: A store request copies the wiper into the shadow and holds busy for STORE_CYC cycles. A store request made while busy is ignored.
- R10: While the shutdown input is low, the shutdown flag (output and control bit 1) reads 1. The wiper keeps its value, and reads and writes still work.
- R11: The SDA pull output changes only on the cycle after a filtered SCL fall, START or STOP. Driven data stays stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain) |
| addr_strap_i | input | 2 | Strapped address bits {A1, A0} |
| shdn_n_i | input | 1 | Active-low shutdown request |
| tap_o | output | 7 | Wiper tap code, 7Fh nearest high terminal |
| shutdown_o | output | 1 | Shutdown flag |

## Verification
The hardest case to reach from the ports is a second store request that arrives while the first is still busy. This has to be seen at the shadow register, which only a later read shows. The bench sets the store window longer than two complete bus transactions. It then issues a store, a burst write that requests a store again with a different wiper value, and a read of address 02h, all inside the window, and expects the first value back. An identification sweep over every strap combination and a wrong device code checks that rejected bytes, and the bytes after them, leave both SDA and the wiper alone.

// File: rtl/wpr_pkg.sv
// Package wpr_pkg
// Shared register addresses and protocol phase type for the wiper controller.
// Assumes byte-wide register addresses and data.
package wpr_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] REG_WIPER  = 8'h00;
    localparam logic [BYTE_W-1:0] REG_CTRL   = 8'h01;
    localparam logic [BYTE_W-1:0] REG_SHADOW = 8'h02;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ID    = 3'd1,
        PH_ADDR  = 3'd2,
        PH_WDATA = 3'd3,
        PH_RDATA = 3'd4
    } phase_t;
endpackage

// File: rtl/wpr_bus_sync.sv
// Module wpr_bus_sync
// Synchronizes SCL and SDA, removes pulses shorter than FILT_LEN cycles and
// produces one-cycle pulses for SCL edges, START and STOP.
// Assumes the bus idles high, so reset values are 1.
module wpr_bus_sync #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [1:0] raw;
    logic [1:0] filt;
    logic [1:0] filt_d;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic             s1, s2;
        logic [CNT_W-1:0] cnt;

        // Two-flop synchronizer followed by a stability counter.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1      <= 1'b1;
                s2      <= 1'b1;
                filt[g] <= 1'b1;
                cnt     <= '0;
            end else begin
                s1 <= raw[g];
                s2 <= s1;
                if (s2 == filt[g]) begin
                    cnt <= '0;
                end else if (cnt == CNT_W'(FILT_LEN - 1)) begin
                    filt[g] <= s2;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) filt_d <= 2'b11;
        else        filt_d <= filt;
    end

    assign sda_q     = filt[1];
    assign scl_rise  = filt[0] & ~filt_d[0];
    assign scl_fall  = ~filt[0] & filt_d[0];
    assign start_det = filt[0] & filt_d[0] & filt_d[1] & ~filt[1];
    assign stop_det  = filt[0] & filt_d[0] & ~filt_d[1] & filt[1];
endmodule

// File: rtl/wpr_target_fsm.sv
// Module wpr_target_fsm
// Bus target protocol engine: identification match, address byte, write
// strobes and read streaming with controller acknowledge.
// Assumes one-cycle event pulses from wpr_bus_sync and a combinational read
// port on the register file addressed by rd_addr.
module wpr_target_fsm
    import wpr_pkg::*;
#(
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_q,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_pull
);
    phase_t            phase;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic [BYTE_W-1:0] addr_q;
    logic              mnack;
    logic              id_match;

    assign id_match = (shreg[7:4] == DEV_CODE) && !shreg[3] && (shreg[2:1] == strap);
    assign rd_addr  = addr_q;

    // Protocol sequencing: shift on SCL rise, act and drive on SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            txreg    <= '0;
            addr_q   <= '0;
            mnack    <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            sda_pull <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                phase    <= PH_ID;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                phase    <= PH_IDLE;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (bitcnt < 4'd8)  shreg  <= {shreg[6:0], sda_q};
                    if (bitcnt == 4'd8) mnack  <= sda_q;
                    if (bitcnt < 4'd9)  bitcnt <= bitcnt + 1'b1;
                end else if (scl_fall) begin
                    if (bitcnt == 4'd8) begin
                        unique case (phase)
                            PH_ID: begin
                                if (id_match) begin
                                    sda_pull <= 1'b1;
                                    mnack    <= 1'b0;
                                    phase    <= shreg[0] ? PH_RDATA : PH_ADDR;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            PH_ADDR: begin
                                addr_q   <= shreg;
                                sda_pull <= 1'b1;
                                phase    <= PH_WDATA;
                            end
                            PH_WDATA: begin
                                wr_en    <= 1'b1;
                                wr_addr  <= addr_q;
                                wr_data  <= shreg;
                                addr_q   <= addr_q + 1'b1;
                                sda_pull <= 1'b1;
                            end
                            PH_RDATA: begin
                                sda_pull <= 1'b0;
                                addr_q   <= addr_q + 1'b1;
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end else if (bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        if (phase == PH_RDATA && !mnack) begin
                            txreg    <= rd_data;
                            sda_pull <= ~rd_data[7];
                        end else begin
                            sda_pull <= 1'b0;
                            if (phase == PH_RDATA) phase <= PH_IDLE;
                        end
                    end else if (phase == PH_RDATA && bitcnt != 4'd0) begin
                        sda_pull <= ~txreg[6];
                        txreg    <= {txreg[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // R11: the pull output moves only after an SCL fall, START or STOP.
    assert_sda_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> $past(scl_fall || start_det || stop_det));

    // R1: in idle the pin is released.
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_pull);

    // R3: outside read data, the pin is pulled only in the acknowledge slot.
    assert_ack_slot_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull && phase != PH_RDATA) |-> (bitcnt >= 4'd8));
endmodule

// File: rtl/wpr_regfile.sv
// Module wpr_regfile
// Wiper, control and shadow registers with power-up recall and a timed
// store. The shadow register stands in for non-volatile storage and holds
// NV_INIT after reset. Writes to the wiper during recall are dropped.
module wpr_regfile
    import wpr_pkg::*;
#(
    parameter int                 WIPER_W    = 7,
    parameter logic [WIPER_W-1:0] NV_INIT    = 7'h40,
    parameter int                 RECALL_CYC = 20,
    parameter int                 STORE_CYC  = 12000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BYTE_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic [BYTE_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0]  rd_data,
    input  logic               shdn_n,
    output logic [WIPER_W-1:0] wiper,
    output logic               shut_flag
);
    localparam int RC_W = $clog2(RECALL_CYC + 1);
    localparam int SC_W = $clog2(STORE_CYC + 1);
    localparam int PAD  = BYTE_W - WIPER_W;

    logic [WIPER_W-1:0] shadow;
    logic               recalling;
    logic [RC_W-1:0]    rcnt;
    logic [SC_W-1:0]    bcnt;
    logic               busy;
    logic               store_req;
    wire                unused_wr_bits = ^wr_data[BYTE_W-1:WIPER_W];

    assign busy      = (bcnt != '0);
    assign store_req = wr_en && (wr_addr == REG_CTRL) && wr_data[0];

    // Wiper register: recall after reset, then bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper     <= '0;
            recalling <= 1'b1;
            rcnt      <= '0;
        end else if (recalling) begin
            if (rcnt == RC_W'(RECALL_CYC - 1)) begin
                wiper     <= shadow;
                recalling <= 1'b0;
            end else begin
                rcnt <= rcnt + 1'b1;
            end
        end else if (wr_en && wr_addr == REG_WIPER) begin
            wiper <= wr_data[WIPER_W-1:0];
        end
    end

    // Shadow store and busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= NV_INIT;
            bcnt   <= '0;
        end else if (store_req && !busy) begin
            shadow <= wiper;
            bcnt   <= SC_W'(STORE_CYC);
        end else if (busy) begin
            bcnt <= bcnt - 1'b1;
        end
    end

    // Shutdown flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) shut_flag <= 1'b0;
        else        shut_flag <= ~shdn_n;
    end

    // Read port.
    always_comb begin
        unique case (rd_addr)
            REG_WIPER:  rd_data = {{PAD{1'b0}}, wiper};
            REG_CTRL:   rd_data = {6'd0, shut_flag, busy};
            REG_SHADOW: rd_data = {{PAD{1'b0}}, shadow};
            default:    rd_data = '0;
        endcase
    end

    // R8: the cycle the recall ends, the wiper holds the shadow value.
    assert_recall_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(recalling) |-> (wiper == $past(shadow)));

    // R9: the shadow takes the wiper value when busy starts.
    assert_store_copies_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (shadow == $past(wiper)));

    // R9: the shadow does not move inside the busy window.
    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(shadow));
endmodule

// File: rtl/i2c_wiper_ctrl.sv
// Module i2c_wiper_ctrl
// Top level: bus conditioning, protocol engine and register file for a
// 7-bit potentiometer wiper. SDA is open-drain: sda_pull_o=1 pulls low.
module i2c_wiper_ctrl #(
    parameter logic [3:0] DEV_CODE   = 4'b1010,
    parameter int         FILT_LEN   = 3,
    parameter int         RECALL_CYC = 20,
    parameter int         STORE_CYC  = 12000,
    parameter logic [6:0] NV_INIT    = 7'h40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [1:0] addr_strap_i,
    input  logic       shdn_n_i,
    output logic [6:0] tap_o,
    output logic       shutdown_o
);
    import wpr_pkg::*;

    logic              sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;

    wpr_bus_sync #(.FILT_LEN(FILT_LEN)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    wpr_target_fsm #(.DEV_CODE(DEV_CODE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (addr_strap_i),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_pull  (sda_pull_o)
    );

    wpr_regfile #(
        .WIPER_W    (7),
        .NV_INIT    (NV_INIT),
        .RECALL_CYC (RECALL_CYC),
        .STORE_CYC  (STORE_CYC)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .shdn_n    (shdn_n_i),
        .wiper     (tap_o),
        .shut_flag (shutdown_o)
    );
endmodule

// File: tb/i2c_wiper_ctrl_test.sv
// Bench for i2c_wiper_ctrl: a bus controller model built from tasks, with a
// wired-AND SDA line. Expected values are computed from the requirements.
module i2c_wiper_ctrl_test;
    localparam int Q = 16;
    localparam logic [3:0] DEV = 4'b1010;
    localparam logic [6:0] NVI = 7'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       shdn_n = 1'b1;
    logic       sda_pull;
    logic [6:0] tap;
    logic       shut;
    wire        sda_bus = sda_m & ~sda_pull;

    int nvec = 0;
    int nmis = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    i2c_wiper_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_pull_o   (sda_pull),
        .addr_strap_i (strap),
        .shdn_n_i     (shdn_n),
        .tap_o        (tap),
        .shutdown_o   (shut)
    );

    task automatic check(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nmis++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        acked = !sda_bus;
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_bus;
            wq(Q - 1);
            check("R11 data stable while SCL high", int'(sda_bus), int'(b[i]));
            wq(1);
            scl_m = 1'b0;
        end
        wq(Q);
        sda_m = ack ? 1'b0 : 1'b1; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] idb(input logic [1:0] a, input bit rd);
        return {DEV, 1'b0, a, rd};
    endfunction

    // Write n bytes from d[] starting at address a (R4).
    task automatic wr_burst(input logic [7:0] a, input logic [7:0] d0,
                            input logic [7:0] d1, input int n);
        bit ak;
        bus_start();
        send_byte(idb(strap, 1'b0), ak); check("R4 id ack", int'(ak), 1);
        send_byte(a, ak);                check("R4 addr ack", int'(ak), 1);
        send_byte(d0, ak);               check("R4 data ack", int'(ak), 1);
        if (n > 1) begin
            send_byte(d1, ak);           check("R4 data2 ack", int'(ak), 1);
        end
        bus_stop();
    endtask

    // Combined read of n (1..4) bytes from address a, NACK on the last (R5).
    task automatic rd_burst(input logic [7:0] a, input int n, output logic [31:0] q);
        bit ak;
        logic [7:0] b;
        q = '0;
        bus_start();
        send_byte(idb(strap, 1'b0), ak); check("R5 id ack", int'(ak), 1);
        send_byte(a, ak);                check("R5 addr ack", int'(ak), 1);
        bus_start();
        send_byte(idb(strap, 1'b1), ak); check("R5 read id ack", int'(ak), 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            q = {q[23:0], b};
        end
        check("R5 released after NACK", int'(sda_pull), 0);
        bus_stop();
    endtask

    initial begin
        logic [31:0] q;
        bit ak;
        // R2: reset state.
        wq(5);
        check("R2 sda released in reset", int'(sda_pull), 0);
        check("R2 tap zero in reset", int'(tap), 0);
        rst_n = 1'b1;
        wq(3);
        check("R2 tap zero before recall", int'(tap), 0);
        wq(30);
        check("R8 recall loads shadow", int'(tap), int'(NVI));

        // R3: identification sweep over every strap code plus a bad device code.
        for (int s = 0; s < 5; s++) begin
            logic [7:0] id;
            bit exp;
            id  = (s < 4) ? idb(2'(s), 1'b0) : {4'b0110, 1'b0, strap, 1'b0};
            exp = (s < 4) && (2'(s) == strap);
            bus_start();
            send_byte(id, ak);
            check("R3 id ack vs strap", int'(ak), int'(exp));
            send_byte(8'h00, ak);
            check("R3 follow-on ack", int'(ak), int'(exp));
            send_byte(8'h11, ak);
            check("R3 follow-on data ack", int'(ak), int'(exp));
            bus_stop();
            check("R3 tap after id test", int'(tap), exp ? 8'h11 : int'(NVI));
            if (exp) wr_burst(8'h00, {1'b0, NVI}, 8'h00, 1);
        end

        // R7 / R4 / R5: wiper sweep with readback.
        for (int v = 0; v <= 136; v += 17) begin
            int w;
            w = (v > 127) ? 127 : v;
            wr_burst(8'h00, 8'(w), 8'h00, 1);
            check("R7 tap equals written code", int'(tap), w);
            rd_burst(8'h00, 1, q);
            check("R5 wiper readback", int'(q[7:0]), w);
        end

        // R6: unimplemented writes acked and discarded; map readback.
        wr_burst(8'h05, 8'hAA, 8'h55, 2);
        rd_burst(8'h05, 2, q);
        check("R6 unimplemented reads zero", int'(q[15:0]), 0);
        wr_burst(8'h00, 8'h2C, 8'h00, 2);
        rd_burst(8'h00, 4, q);
        check("R4 auto-increment write then R6 map", int'(q), 32'h2C00_4000);

        // R9: store, then a second store while busy is ignored.
        wr_burst(8'h00, 8'h15, 8'h01, 2);
        rd_burst(8'h01, 2, q);
        check("R9 busy set after store", int'(q[8]), 1);
        check("R9 shadow holds stored wiper", int'(q[7:0]), 8'h15);
        wr_burst(8'h00, 8'h33, 8'h01, 2);
        rd_burst(8'h02, 1, q);
        check("R9 store while busy ignored", int'(q[7:0]), 8'h15);
        wq(12000);
        rd_burst(8'h01, 1, q);
        check("R9 busy clears", int'(q[0]), 0);
        wr_burst(8'h01, 8'h01, 8'h00, 1);
        rd_burst(8'h02, 1, q);
        check("R9 later store accepted", int'(q[7:0]), 8'h33);

        // R10: shutdown flag, wiper kept, access still works.
        shdn_n = 1'b0;
        wq(4);
        check("R10 shutdown flag", int'(shut), 1);
        check("R10 wiper kept", int'(tap), 8'h33);
        wr_burst(8'h00, 8'h7F, 8'h00, 1);
        check("R10 write in shutdown", int'(tap), 8'h7F);
        rd_burst(8'h01, 1, q);
        check("R10 ctrl shutdown bit", int'(q[1]), 1);
        shdn_n = 1'b1;
        wq(4);
        check("R10 flag clears", int'(shut), 0);

        // R1: STOP mid-transfer, then bytes without START are ignored.
        bus_start();
        send_byte(idb(strap, 1'b0), ak);
        send_byte(8'h00, ak);
        bus_stop();
        check("R1 released after stop", int'(sda_pull), 0);
        scl_m = 1'b0; wq(Q);
        send_byte(8'h0A, ak);
        check("R1 no ack when idle", int'(ak), 0);
        scl_m = 1'b1; sda_m = 1'b1; wq(Q);
        check("R1 tap unchanged when idle", int'(tap), 8'h7F);

        // R1: START in the middle of a byte restarts identification.
        bus_start();
        send_byte(idb(strap, 1'b0), ak);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
        send_byte(idb(strap, 1'b0), ak);
        check("R1 restart id ack", int'(ak), 1);
        send_byte(8'h00, ak);
        send_byte(8'h06, ak);
        bus_stop();
        check("R1 write after restart", int'(tap), 8'h06);

        // R2: reset again restores recall from NV_INIT.
        rst_n = 1'b0; wq(3);
        check("R2 tap zero in second reset", int'(tap), 0);
        rst_n = 1'b1; wq(30);
        check("R8 recall after second reset", int'(tap), int'(NVI));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nvec++;
            nmis++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end
endmodule